// File: doc/BRIEF.md
# Cursor Register Arming Unit

This block is the register front end of a double-buffered hardware cursor plane. Software writes four cursor registers over a simple write port: control, position, base address and partial height. Every write lands in a pending copy. The scanout logic only ever sees the active copies.

Pending values move to the active copies only at a vertical-blank strobe, and only when an update has been armed. Two writes arm an update:
- a base-address write, in any state;
- a control write that turns a disabled plane on.

Any other cursor register write cancels an armed update that has not yet been latched. Software therefore follows a fixed order: partial height, then control, then position, then base. A change to position alone still needs a base write after it.

The block drives the active values, the position decoded to signed X and Y, the decoded partial height, the plane enable with its mode field for readback, and a status bit that is high while an update is armed.

Top module: `cursor_arm_regs`

## Requirements
- R1: After reset, all active and pending registers are zero, `armed` is low and `cur_enable` is low.
- R2: A register write changes only the pending copy. The active outputs change only on a cycle where `vblank` is high and `armed` was already high.
- R3: A write to the base register (`wr_sel`=2) sets `armed`. On the next `vblank` strobe, all four pending registers move to the active outputs together and `armed` clears.
- R4: A control write (`wr_sel`=0) whose mode field `wr_data[MODE_W-1:0]` is nonzero, while the active mode is zero, sets `armed`.
- R5: A control write made while the plane is active, or one that carries a zero mode, does not arm. It clears any armed update.
- R6: A write to position (`wr_sel`=1) or partial height (`wr_sel`=3) clears `armed`. A following `vblank` then transfers nothing.
- R7: When an arming write and `vblank` fall in the same cycle, the transfer uses the pending values from before that write. `armed` then stays high, and the new value lands at the following `vblank`.
- R8: Position uses sign-magnitude fields:
  - X magnitude in bits [POS_W-1:0], X sign in bit DW/2-1;
  - Y magnitude in bits [DW/2+POS_W-1:DW/2], Y sign in bit DW-1.
  
  `cur_x` and `cur_y` give the signed values, and a set sign bit means negative.
- R9: Partial height holds its enable in bit DW-1 and the height minus one in bits [HGT_W-1:0]. `cur_ph_lines` reports that field plus one.
- R10: `cur_mode` reports the active mode field. `cur_enable` is high exactly when that field is nonzero.
- R11: `armed` stays high from the arming write until the `vblank` that latches the update, unless another write cancels it first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 position, 2 base, 3 partial height |
| wr_data | input | DW | Write data |
| vblank | input | 1 | Single-cycle vertical-blank strobe |
| cur_ctrl | output | DW | Active control word |
| cur_base | output | DW | Active base address |
| cur_x | output | POS_W+1 | Active X position, signed |
| cur_y | output | POS_W+1 | Active Y position, signed |
| cur_ph_en | output | 1 | Active partial-height enable |
| cur_ph_lines | output | HGT_W+1 | Active partial height in lines |
| cur_mode | output | MODE_W | Active mode field |
| cur_enable | output | 1 | Plane on (mode nonzero) |
| armed | output | 1 | Update armed, waiting for vblank |

## Verification
The bench builds the block with its defaults:
- DW = 32, so the sign bits sit at bits 15 and 31;
- POS_W = 12;
- HGT_W = 8, so a height field of 7 gives 8 lines;
- MODE_W = 3, so modes 2, 3 and 5 are all distinct nonzero values.

At these widths the bench can check a negative X beside a positive Y, and it can see a change from one enabled mode to another. It also reaches the same-cycle arm and blank case, which shows whether the transfer used the pending values from before the write.

// File: rtl/cursor_arm_regs.sv
module cursor_arm_regs #(
  parameter int DW     = 32,
  parameter int POS_W  = 12,
  parameter int HGT_W  = 8,
  parameter int MODE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [DW-1:0]           wr_data,
  input  logic                    vblank,
  output logic [DW-1:0]           cur_ctrl,
  output logic [DW-1:0]           cur_base,
  output logic signed [POS_W:0]   cur_x,
  output logic signed [POS_W:0]   cur_y,
  output logic                    cur_ph_en,
  output logic [HGT_W:0]          cur_ph_lines,
  output logic [MODE_W-1:0]       cur_mode,
  output logic                    cur_enable,
  output logic                    armed
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_POS  = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;
  localparam logic [1:0] SEL_PH   = 2'd3;
  localparam int HALF   = DW / 2;
  localparam int XS_BIT = HALF - 1;
  localparam int YS_BIT = DW - 1;
  localparam int PHE_BIT = DW - 1;

  logic [DW-1:0] pend_ctrl, pend_pos, pend_base, pend_ph;
  logic [DW-1:0] act_pos, act_ph;

  logic wr_ctrl, wr_pos, wr_base, wr_ph;
  assign wr_ctrl = wr_en && wr_sel == SEL_CTRL;
  assign wr_pos  = wr_en && wr_sel == SEL_POS;
  assign wr_base = wr_en && wr_sel == SEL_BASE;
  assign wr_ph   = wr_en && wr_sel == SEL_PH;

  logic turning_on, arm_wr, latch;
  assign turning_on = wr_ctrl && cur_ctrl[MODE_W-1:0] == '0 && wr_data[MODE_W-1:0] != '0;
  assign arm_wr     = wr_base || turning_on;
  assign latch      = vblank && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_ctrl <= '0;
      pend_pos  <= '0;
      pend_base <= '0;
      pend_ph   <= '0;
    end else begin
      if (wr_ctrl) pend_ctrl <= wr_data;
      if (wr_pos)  pend_pos  <= wr_data;
      if (wr_base) pend_base <= wr_data;
      if (wr_ph)   pend_ph   <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ctrl <= '0;
      cur_base <= '0;
      act_pos  <= '0;
      act_ph   <= '0;
    end else if (latch) begin
      cur_ctrl <= pend_ctrl;
      cur_base <= pend_base;
      act_pos  <= pend_pos;
      act_ph   <= pend_ph;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                armed <= 1'b0;
    else if (arm_wr)           armed <= 1'b1;
    else if (wr_en || vblank)  armed <= 1'b0;
  end

  logic [POS_W:0] x_mag, y_mag;
  assign x_mag = {1'b0, act_pos[POS_W-1:0]};
  assign y_mag = {1'b0, act_pos[HALF+POS_W-1:HALF]};
  assign cur_x = act_pos[XS_BIT] ? -$signed(x_mag) : $signed(x_mag);
  assign cur_y = act_pos[YS_BIT] ? -$signed(y_mag) : $signed(y_mag);

  assign cur_ph_en    = act_ph[PHE_BIT];
  assign cur_ph_lines = {1'b0, act_ph[HGT_W-1:0]} + 1'b1;

  assign cur_mode   = cur_ctrl[MODE_W-1:0];
  assign cur_enable = |cur_mode;

  p_arm_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == SEL_BASE |=> armed);

  p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && vblank |=> cur_base == $past(pend_base) && cur_ctrl == $past(pend_ctrl));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && vblank) |=> $stable(cur_base) && $stable(cur_ctrl) && $stable(cur_x));

  p_arm_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == SEL_CTRL && !cur_enable && wr_data[MODE_W-1:0] != '0 |=> armed);

  p_no_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == SEL_CTRL && cur_enable |=> !armed);

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == SEL_POS || wr_sel == SEL_PH) |=> !armed);

  p_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !vblank && !wr_en |=> armed);

endmodule

// File: tb/cursor_arm_regs_test.sv
module cursor_arm_regs_test;
  localparam int DW = 32, POS_W = 12, HGT_W = 8, MODE_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic vblank = 1'b0;
  logic [DW-1:0] cur_ctrl, cur_base;
  logic signed [POS_W:0] cur_x, cur_y;
  logic cur_ph_en;
  logic [HGT_W:0] cur_ph_lines;
  logic [MODE_W-1:0] cur_mode;
  logic cur_enable, armed;

  always #10 clk = ~clk;

  cursor_arm_regs #(.DW(DW), .POS_W(POS_W), .HGT_W(HGT_W), .MODE_W(MODE_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vblank(vblank), .cur_ctrl(cur_ctrl), .cur_base(cur_base), .cur_x(cur_x),
    .cur_y(cur_y), .cur_ph_en(cur_ph_en), .cur_ph_lines(cur_ph_lines),
    .cur_mode(cur_mode), .cur_enable(cur_enable), .armed(armed));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [1:0] s, input logic [DW-1:0] d, input bit vb);
    @(negedge clk);
    wr_en = w; wr_sel = s; wr_data = d; vblank = vb;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; vblank = 1'b0;
  endtask

  // {kind[1:0] (0 write, 1 vblank, 2 write+vblank), sel[1:0], data[31:0], armed, enable, base[31:0]}
  localparam int NV = 18;
  localparam logic [69:0] VEC [NV] = '{
    {2'd0, 2'd3, 32'h8000_0007, 1'b0, 1'b0, 32'h0},     // R6 ph write no arm
    {2'd0, 2'd0, 32'h0000_0002, 1'b1, 1'b0, 32'h0},     // R4 enable arms
    {2'd0, 2'd1, 32'h0000_0010, 1'b0, 1'b0, 32'h0},     // R6 pos cancels
    {2'd1, 2'd0, 32'h0,         1'b0, 1'b0, 32'h0},     // R6 no transfer
    {2'd0, 2'd0, 32'h0000_0002, 1'b1, 1'b0, 32'h0},     // R4
    {2'd0, 2'd2, 32'h0000_1000, 1'b1, 1'b0, 32'h0},     // R2 pending only
    {2'd1, 2'd0, 32'h0,         1'b0, 1'b1, 32'h1000},  // R3 transfer
    {2'd0, 2'd2, 32'h0000_2000, 1'b1, 1'b1, 32'h1000},  // R11
    {2'd0, 2'd1, 32'h0000_0005, 1'b0, 1'b1, 32'h1000},  // R6 cancel
    {2'd1, 2'd0, 32'h0,         1'b0, 1'b1, 32'h1000},  // R6
    {2'd0, 2'd2, 32'h0000_3000, 1'b1, 1'b1, 32'h1000},  // R3
    {2'd1, 2'd0, 32'h0,         1'b0, 1'b1, 32'h3000},  // R3
    {2'd0, 2'd0, 32'h0000_0000, 1'b0, 1'b1, 32'h3000},  // R5 zero mode no arm
    {2'd1, 2'd0, 32'h0,         1'b0, 1'b1, 32'h3000},  // R5
    {2'd0, 2'd2, 32'h0000_3000, 1'b1, 1'b1, 32'h3000},  // R3
    {2'd1, 2'd0, 32'h0,         1'b0, 1'b0, 32'h3000},  // R10 disabled
    {2'd0, 2'd2, 32'h0000_4000, 1'b1, 1'b0, 32'h3000},  // R3
    {2'd2, 2'd2, 32'h0000_5000, 1'b1, 1'b0, 32'h4000}   // R7 same cycle
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 armed", armed, 0);
    chk("R1 enable", cur_enable, 0);
    chk("R1 base", cur_base, 0);
    chk("R1 ctrl", cur_ctrl, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][69:68] != 2'd1, VEC[i][67:66], VEC[i][65:34], VEC[i][69:68] != 2'd0);
      chk($sformatf("R2/R3 vec%0d armed", i), armed, VEC[i][33]);
      chk($sformatf("R10 vec%0d enable", i), cur_enable, VEC[i][32]);
      chk($sformatf("R3 vec%0d base", i), cur_base, VEC[i][31:0]);
    end

    step(1'b0, 2'd0, '0, 1'b1);
    chk("R7 held arm base", cur_base, 32'h5000);
    chk("R7 armed cleared", armed, 0);
    chk("R9 ph enable", cur_ph_en, 1);
    chk("R9 ph lines", cur_ph_lines, 8);

    step(1'b1, 2'd1, 32'h0007_8005, 1'b0);
    step(1'b1, 2'd2, 32'h0000_6000, 1'b0);
    step(1'b0, 2'd0, '0, 1'b1);
    chk("R8 x neg", cur_x, -5);
    chk("R8 y pos", cur_y, 7);
    step(1'b1, 2'd1, 32'h8003_0009, 1'b0);
    step(1'b1, 2'd2, 32'h0000_6000, 1'b0);
    step(1'b0, 2'd0, '0, 1'b1);
    chk("R8 x pos", cur_x, 9);
    chk("R8 y neg", cur_y, -3);

    step(1'b1, 2'd0, 32'h0000_0005, 1'b0);
    chk("R4 armed", armed, 1);
    step(1'b0, 2'd0, '0, 1'b1);
    chk("R10 mode", cur_mode, 5);
    chk("R10 enable", cur_enable, 1);
    step(1'b1, 2'd0, 32'h0000_0003, 1'b0);
    chk("R5 no arm while on", armed, 0);
    step(1'b0, 2'd0, '0, 1'b1);
    chk("R5 mode kept", cur_mode, 5);
    step(1'b1, 2'd2, 32'h0000_7000, 1'b0);
    chk("R11 armed until blank", armed, 1);
    step(1'b0, 2'd0, '0, 1'b0);
    chk("R11 armed idle", armed, 1);
    step(1'b0, 2'd0, '0, 1'b1);
    chk("R3 mode updated", cur_mode, 3);
    chk("R3 base updated", cur_base, 32'h7000);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule